// File: doc/BRIEF.md
# Oversampling Serial Receiver with Tagged Receive FIFO

This block is the receive half of a classic asynchronous serial port. It watches a serial line and times each character with a 16x oversampling enable. A falling edge on the idle line starts a tick counter. The line is checked again half a bit later, so a short glitch is thrown away instead of being assembled into a character. After that, every data bit, the optional parity bit and the stop bit are sampled in the middle of their bit periods.

Each finished character goes into a first-in first-out store together with its own error tags (parity, framing, break). The oldest entry is the holding register that the host sees. When the host pops it, the error outputs change straight away to show the tags of the next byte. A data-ready flag, a maskable data-ready interrupt and a sticky overrun flag complete the host-facing side.

Top module: `rx_lane`

## Requirements
- R1: A high-to-low change of `rxd_i`, seen on a tick, starts a character. On the 8th tick after that, the line is checked again. If it is high, the attempt is dropped and no byte is stored.
- R2: Data bits arrive LSB first, and each one is sampled 16 ticks after the previous sample. Timing moves forward only on cycles with `tick16_i` high, so a slower tick rate stretches the bit period.
- R3: With `parity_en_i` high, one parity bit follows the data. `parity_odd_i` = 0 selects even parity, meaning the data bits plus the parity bit hold an even number of ones. `parity_odd_i` = 1 selects odd parity. A byte whose parity does not match is stored with its parity tag set.
- R4: The store holds 16 bytes in arrival order. `rhr_o` shows the oldest byte. A one-cycle pulse on `rd_i` while data is ready removes that byte.
- R5: A byte whose stop-bit sample is low is stored with its framing tag set. A character in which every sample, including parity and stop, is low is stored as byte 0x00 with both the break tag and the framing tag set.
- R6: The tags are kept per entry. `parity_err_o`, `frame_err_o` and `break_o` show the tags of the oldest byte and change in the cycle after a pop. They are 0, and so is `rhr_o`, while the store is empty.
- R7: `data_ready_o` is high exactly when the store is not empty. `rx_irq_o` is high when `data_ready_o` and `irq_en_i` are both high.
- R8: A character that completes while the store is full is discarded, and stored bytes are kept. This sets `overrun_o`, which stays set until the next `rd_i` pulse.
- R9: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick16_i | input | 1 | Oversampling enable, 16 per bit period |
| rxd_i | input | 1 | Serial line, idle high |
| parity_en_i | input | 1 | Expect a parity bit after the data |
| parity_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| irq_en_i | input | 1 | Data-ready interrupt enable |
| rd_i | input | 1 | Host pop of the holding register |
| rhr_o | output | 8 | Oldest received byte |
| data_ready_o | output | 1 | Store not empty |
| parity_err_o | output | 1 | Parity tag of the oldest byte |
| frame_err_o | output | 1 | Framing tag of the oldest byte |
| break_o | output | 1 | Break tag of the oldest byte |
| overrun_o | output | 1 | A byte was lost because the store was full |
| rx_irq_o | output | 1 | Data-ready interrupt |

## Verification
The bench uses the default parameters: 8 data bits, 16x oversampling and a 16-entry store. With these values, 17 back-to-back characters are enough to fill the store completely and then trigger an overrun. That in turn lets the bench check that all 16 stored bytes come out in arrival order and that the lost byte never appears. Running the tick enable on alternate cycles doubles the bit period, which checks that timing depends on the tick and not on the clock. Frames with a flipped parity bit, a low stop bit and a fully low line are mixed in the store, which checks that each pop switches the error outputs to the new head byte's own tags.

// File: rtl/rx_lane_pkg.sv
package rx_lane_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rx_tag_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr <= '1;
    else         sr <= {sr[STAGES-2:0], d_i};
  end

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/rx_sampler.sv
module rx_sampler
  import rx_lane_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output rx_tag_t           tag_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              line_q;
  logic              par_bad;
  logic              all_low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      line_q  <= 1'b1;
      par_bad <= 1'b0;
      all_low <= 1'b0;
      valid_o <= 1'b0;
      data_o  <= '0;
      tag_o   <= '0;
    end else begin
      valid_o <= 1'b0;
      if (tick_i) begin
        line_q <= line_i;
        unique case (state)
          ST_IDLE: begin
            if (line_q && !line_i) begin
              state <= ST_START;
              cnt   <= '0;
            end
          end
          ST_START: begin
            if (cnt == HALF_M1) begin
              cnt <= '0;
              if (!line_i) begin
                // start bit confirmed at its centre
                state   <= ST_DATA;
                bit_idx <= '0;
                par_bad <= 1'b0;
                all_low <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt == FULL_M1) begin
              cnt     <= '0;
              shreg   <= {line_i, shreg[DATA_W-1:1]};
              all_low <= all_low & ~line_i;
              if (bit_idx == LAST_BIT) state <= par_en_i ? ST_PAR : ST_STOP;
              else                     bit_idx <= bit_idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (cnt == FULL_M1) begin
              cnt     <= '0;
              par_bad <= line_i ^ (^shreg) ^ par_odd_i;
              all_low <= all_low & ~line_i;
              state   <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt == FULL_M1) begin
              cnt        <= '0;
              valid_o    <= 1'b1;
              data_o     <= shreg;
              tag_o.perr <= par_bad;
              tag_o.ferr <= ~line_i;
              tag_o.brk  <= all_low & ~line_i;
              state      <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo
  import rx_lane_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  rx_tag_t           push_tag_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_data_o,
  output rx_tag_t           head_tag_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W:0]   FULL_CNT = (PTR_W+1)'(DEPTH);

  logic [DATA_W-1:0] data_mem [DEPTH];
  rx_tag_t           tag_mem  [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [PTR_W:0]    count;

  assign empty_o = (count == '0);
  assign full_o  = (count == FULL_CNT);

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      data_mem[wr_ptr] <= push_data_i;
      tag_mem[wr_ptr]  <= push_tag_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_i) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_i)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_i, pop_i})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_data_o = data_mem[rd_ptr];
  assign head_tag_o  = tag_mem[rd_ptr];
endmodule

// File: rtl/rx_lane.sv
module rx_lane
  import rx_lane_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic              rxd_i,
  input  logic              parity_en_i,
  input  logic              parity_odd_i,
  input  logic              irq_en_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rhr_o,
  output logic              data_ready_o,
  output logic              parity_err_o,
  output logic              frame_err_o,
  output logic              break_o,
  output logic              overrun_o,
  output logic              rx_irq_o
);
  logic              line_s;
  logic              byte_vld;
  logic [DATA_W-1:0] byte_data;
  rx_tag_t           byte_tag;
  logic [DATA_W-1:0] head_data;
  rx_tag_t           head_tag;
  logic              empty, full, push, pop;

  rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (line_s)
  );

  rx_sampler #(.DATA_W(DATA_W), .OVS(OVS)) i_sampler (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick16_i),
    .line_i   (line_s),
    .par_en_i (parity_en_i),
    .par_odd_i(parity_odd_i),
    .valid_o  (byte_vld),
    .data_o   (byte_data),
    .tag_o    (byte_tag)
  );

  assign push = byte_vld & ~full;
  assign pop  = rd_i & ~empty;

  rx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_data_i(byte_data),
    .push_tag_i (byte_tag),
    .pop_i      (pop),
    .head_data_o(head_data),
    .head_tag_o (head_tag),
    .empty_o    (empty),
    .full_o     (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                overrun_o <= 1'b0;
    else if (byte_vld && full)  overrun_o <= 1'b1;
    else if (rd_i)              overrun_o <= 1'b0;
  end

  assign data_ready_o = ~empty;
  assign rhr_o        = empty ? '0 : head_data;
  assign parity_err_o = ~empty & head_tag.perr;
  assign frame_err_o  = ~empty & head_tag.ferr;
  assign break_o      = ~empty & head_tag.brk;
  assign rx_irq_o     = irq_en_i & ~empty;
endmodule

// File: rtl/rx_lane_chk.sv
module rx_lane_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic [DATA_W-1:0] rhr_o,
  input logic              data_ready_o,
  input logic              parity_err_o,
  input logic              frame_err_o,
  input logic              break_o,
  input logic              overrun_o,
  input logic              rx_irq_o
);
  assert_irq_needs_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> data_ready_o);

  assert_tags_clear_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_ready_o |-> !(parity_err_o || frame_err_o || break_o) && rhr_o == '0);

  assert_break_zero_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_o |-> frame_err_o && rhr_o == '0);

  assert_head_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_ready_o && !rd_i |=> data_ready_o && $stable(rhr_o));

  assert_overrun_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !rd_i |=> overrun_o);
endmodule

bind rx_lane rx_lane_chk #(.DATA_W(DATA_W)) i_rx_lane_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_i        (rd_i),
  .rhr_o       (rhr_o),
  .data_ready_o(data_ready_o),
  .parity_err_o(parity_err_o),
  .frame_err_o (frame_err_o),
  .break_o     (break_o),
  .overrun_o   (overrun_o),
  .rx_irq_o    (rx_irq_o)
);

// File: tb/test_rx_lane.sv
module test_rx_lane;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick16_i = 1'b1;
  logic       rxd_i = 1'b1;
  logic       parity_en_i = 1'b0;
  logic       parity_odd_i = 1'b0;
  logic       irq_en_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] rhr_o;
  logic       data_ready_o, parity_err_o, frame_err_o, break_o, overrun_o, rx_irq_o;

  int  tests = 0;
  int  fails = 0;
  bit  done = 1'b0;
  bit  half_rate = 1'b0;

  always #4 clk_i = ~clk_i;

  always @(negedge clk_i) tick16_i <= half_rate ? ~tick16_i : 1'b1;

  rx_lane i_rx_lane (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick16_i(tick16_i), .rxd_i(rxd_i),
    .parity_en_i(parity_en_i), .parity_odd_i(parity_odd_i), .irq_en_i(irq_en_i),
    .rd_i(rd_i), .rhr_o(rhr_o), .data_ready_o(data_ready_o),
    .parity_err_o(parity_err_o), .frame_err_o(frame_err_o), .break_o(break_o),
    .overrun_o(overrun_o), .rx_irq_o(rx_irq_o)
  );

  // data, parity_en, odd, flip parity, low stop
  localparam int NV = 8;
  localparam logic [11:0] VEC [NV] = '{
    {8'hA5, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h01, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h80, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h7E, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'hC3, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h5A, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'hFF, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int cyc);
    rxd_i = v;
    repeat (cyc) @(negedge clk_i);
  endtask

  task automatic send(input logic [7:0] d, input bit pe, input bit odd,
                      input bit flip, input bit bad_stop, input int bit_cyc);
    parity_en_i  = pe;
    parity_odd_i = odd;
    hold(1'b0, bit_cyc);
    for (int i = 0; i < 8; i++) hold(d[i], bit_cyc);
    if (pe) hold((^d) ^ odd ^ flip, bit_cyc);
    hold(~bad_stop, bit_cyc);
    hold(1'b1, 2 * bit_cyc);
  endtask

  task automatic pop();
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check("R9 ready", data_ready_o, 0);
    check("R9 rhr", rhr_o, 0);
    check("R9 flags", {parity_err_o, frame_err_o, break_o, overrun_o, rx_irq_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R2 R3 R5 table of frames
    for (int v = 0; v < NV; v++) begin
      logic [7:0] d;
      d = VEC[v][11:4];
      send(d, VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0], 16);
      check("R7 ready", data_ready_o, 1);
      check("R2 data", rhr_o, d);
      check("R3 parity tag", parity_err_o, VEC[v][3] & VEC[v][1]);
      check("R5 frame tag", frame_err_o, VEC[v][0]);
      check("R5 break tag", break_o, 0);
      pop();
      check("R4 empty after pop", data_ready_o, 0);
    end

    // R1 false start: short low pulse
    hold(1'b0, 4);
    hold(1'b1, 300);
    check("R1 glitch ignored", data_ready_o, 0);
    send(8'h96, 1'b0, 1'b0, 1'b0, 1'b0, 16);
    check("R1 next frame", rhr_o, 8'h96);
    pop();

    // R2 half tick rate doubles bit period
    half_rate = 1'b1;
    send(8'h2D, 1'b0, 1'b0, 1'b0, 1'b0, 32);
    half_rate = 1'b0;
    check("R2 half rate data", rhr_o, 8'h2D);
    pop();

    // R5 break: line low for whole character
    parity_en_i = 1'b0;
    hold(1'b0, 160);
    hold(1'b1, 48);
    check("R5 break byte", rhr_o, 0);
    check("R5 break flags", {break_o, frame_err_o, parity_err_o}, 3'b110);
    pop();

    // R6 tags follow the head
    send(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 16);
    send(8'h22, 1'b1, 1'b0, 1'b1, 1'b0, 16);
    send(8'h33, 1'b0, 1'b0, 1'b0, 1'b1, 16);
    check("R6 head0", {rhr_o, parity_err_o, frame_err_o}, {8'h11, 2'b00});
    // R7 interrupt masking
    check("R7 irq masked", rx_irq_o, 0);
    irq_en_i = 1'b1;
    @(negedge clk_i);
    check("R7 irq on", rx_irq_o, 1);
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    check("R6 head1 next cycle", {rhr_o, parity_err_o, frame_err_o}, {8'h22, 2'b10});
    pop();
    check("R6 head2", {rhr_o, parity_err_o, frame_err_o}, {8'h33, 2'b01});
    pop();
    check("R6 empty tags", {parity_err_o, frame_err_o, break_o}, 0);
    check("R7 irq off empty", rx_irq_o, 0);

    // R8 R4 fill 16 then overrun
    for (int i = 0; i < 17; i++) send(8'h40 + 8'(i), 1'b0, 1'b0, 1'b0, 1'b0, 16);
    check("R8 overrun set", overrun_o, 1);
    check("R4 head kept", rhr_o, 8'h40);
    for (int i = 0; i < 16; i++) begin
      check("R4 order", rhr_o, 8'h40 + 8'(i));
      pop();
      if (i == 0) check("R8 overrun cleared", overrun_o, 0);
    end
    check("R8 lost byte absent", data_ready_o, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule